// File: doc/BRIEF.md
# Tick-Windowed Interval Relation Monitor

This block is a synthesizable runtime monitor that watches two level-type status inputs and one pulse input. It flags a bounded-delay relation between them when that relation fails. The delay is measured in strobes of a separate logical tick input, not in system clock cycles. Two relation kinds are supported. In the ordering kind, the second level must rise within a tick window that opens when the first level ends. In the ending kind, a pulse opens the window, and the first level must drop inside it.

The lower and upper bounds of the window are plain unsigned numbers, and a zero bound is open-ended. So `[0,n]` means "no later than n ticks", `[m,0]` means "no sooner than m ticks", `[m,m]` means "exactly m ticks", and `[0,0]` reduces the ordering kind to pure sequencing. The monitor samples the bounds at the moment counting starts. It reports each failure as a one-cycle pulse and shows through a busy flag that a check is pending. Rise and fall detection of the level inputs is internal.

Top module: `tick_window_monitor`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `violation` and `busy` are 0.
- R2: With `mode` = 0 (ordering), a high `lvl_first` arms the monitor, and `busy` reads 1 after that edge. A falling edge of `lvl_first` starts the count at zero, and a tick in that same cycle is not counted.
- R3: A target edge (a rise of `lvl_second` in ordering mode, a fall of `lvl_first` in ending mode) is accepted when the tick count is within the window. A tick that arrives in the same cycle as the target is included in the count. On acceptance no violation is raised and the monitor goes idle (`busy` = 0).
- R4: A target edge that arrives while the count is below a non-zero `bound_lo` raises a violation, and the monitor goes idle.
- R5: With a non-zero `bound_hi`, a tick that would raise the count above `bound_hi` while the monitor is still waiting raises a violation, and the monitor goes idle.
- R6: A zero bound is unbounded on its side. With `[0,0]` in ordering mode, a rise of `lvl_second` any number of cycles after `lvl_first` has ended is accepted.
- R7: In ordering mode, a rise of `lvl_second` while the monitor is idle or armed (before `lvl_first` has ended) raises a violation.
- R8: With `mode` = 1 (ending), a `trigger` pulse starts the count at zero and sets `busy`. A fall of `lvl_first` when no count is pending has no effect, and `lvl_second` is ignored.
- R9: A new activation while a count is pending restarts it. In ordering mode, a high `lvl_first` returns the monitor to armed. In ending mode, a new `trigger` reloads the count at zero and samples the bounds again.
- R10: `violation` is a single-cycle pulse. It is high during the cycle after the clock edge at which the failing input was sampled.
- R11: The bounds are sampled when counting starts. Changing `bound_lo` or `bound_hi` afterwards does not affect the pending check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = ordering relation, 1 = ending relation |
| lvl_first | input | 1 | First observed status level |
| lvl_second | input | 1 | Second observed status level (ordering mode) |
| trigger | input | 1 | Event pulse that opens the window (ending mode) |
| tick | input | 1 | Logical-clock strobe, one count per cycle it is high |
| bound_lo | input | BOUND_W | Minimum tick count, 0 = none |
| bound_hi | input | BOUND_W | Maximum tick count, 0 = none |
| violation | output | 1 | One-cycle failure pulse |
| busy | output | 1 | A check is armed or counting |

## Verification
Every result of this monitor is registered once. A violation or a busy change caused by inputs sampled at one rising edge can be seen from that edge until the next. The bench drives inputs on the falling edge and samples both outputs on the following falling edge, which is exactly one edge after the stimulus. A cycle-level model in the bench predicts both outputs for every cycle of random and directed stimulus. Directed sequences also pin hand-computed values on the cycle where each boundary case (early, late, exact, open, restart) resolves.

// File: rtl/tiw_pkg.sv
package tiw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_COUNT = 2'd2
    } tiw_state_e;

    typedef enum logic {
        MODE_ORDER = 1'b0,
        MODE_END   = 1'b1
    } tiw_mode_e;

    typedef struct packed {
        tiw_state_e state;
        logic       viol;
    } tiw_ctrl_t;

endpackage

// File: rtl/tiw_edges.sv
module tiw_edges #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign rise_o[i] = lvl_i[i] & ~prev_q[i];
        assign fall_o[i] = prev_q[i] & ~lvl_i[i];
    end
endmodule

// File: rtl/tiw_window.sv
module tiw_window #(
    parameter int BOUND_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               run_i,
    input  logic               tick_i,
    input  logic [BOUND_W-1:0] lo_i,
    input  logic [BOUND_W-1:0] hi_i,
    output logic               fits_o,
    output logic               expire_o
);
    localparam int CW = BOUND_W + 1;
    localparam logic [CW-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [CW-1:0]      cnt;
        logic [BOUND_W-1:0] lo;
        logic [BOUND_W-1:0] hi;
    } win_t;

    win_t          d, q;
    logic [CW-1:0] nxt;
    logic [CW-1:0] lo_ext, hi_ext;

    always_comb begin
        lo_ext = {1'b0, q.lo};
        hi_ext = {1'b0, q.hi};
        nxt    = (q.cnt == CNT_TOP) ? q.cnt : q.cnt + {{(CW-1){1'b0}}, tick_i};
        fits_o   = ((q.lo == '0) || (nxt >= lo_ext)) &&
                   ((q.hi == '0) || (nxt <= hi_ext));
        expire_o = (q.hi != '0) && tick_i && (q.cnt >= hi_ext);
        d = q;
        if (load_i) begin
            d.cnt = '0;
            d.lo  = lo_i;
            d.hi  = hi_i;
        end else if (run_i) begin
            d.cnt = nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i && q.hi != '0) |-> (q.cnt <= hi_ext));

    // R9
    reload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (q.cnt == '0));
endmodule

// File: rtl/tick_window_monitor.sv
module tick_window_monitor
    import tiw_pkg::*;
#(
    parameter int BOUND_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode,
    input  logic               lvl_first,
    input  logic               lvl_second,
    input  logic               trigger,
    input  logic               tick,
    input  logic [BOUND_W-1:0] bound_lo,
    input  logic [BOUND_W-1:0] bound_hi,
    output logic               violation,
    output logic               busy
);
    tiw_ctrl_t  d, q;
    logic [1:0] rise_w, fall_w;
    logic       first_fall, second_rise;
    logic       load, run, fits, expire, target, ordering;

    tiw_edges #(.N(2)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  ({lvl_second, lvl_first}),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    assign first_fall  = fall_w[0];
    assign second_rise = rise_w[1];

    tiw_window #(.BOUND_W(BOUND_W)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .run_i    (run),
        .tick_i   (tick),
        .lo_i     (bound_lo),
        .hi_i     (bound_hi),
        .fits_o   (fits),
        .expire_o (expire)
    );

    always_comb begin
        ordering = (tiw_mode_e'(mode) == MODE_ORDER);
        target   = ordering ? second_rise : first_fall;
        d        = q;
        d.viol   = 1'b0;
        load     = 1'b0;
        run      = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (ordering) begin
                    if (second_rise)    d.viol  = 1'b1;
                    else if (lvl_first) d.state = ST_ARMED;
                end else if (trigger) begin
                    load    = 1'b1;
                    d.state = ST_COUNT;
                end
            end
            ST_ARMED: begin
                if (!ordering) begin
                    d.state = ST_IDLE;
                end else if (second_rise) begin
                    d.viol  = 1'b1;
                    d.state = ST_IDLE;
                end else if (first_fall) begin
                    load    = 1'b1;
                    d.state = ST_COUNT;
                end
            end
            ST_COUNT: begin
                run = 1'b1;
                if (target) begin
                    d.viol  = !fits;
                    d.state = ST_IDLE;
                end else if (expire) begin
                    d.viol  = 1'b1;
                    d.state = ST_IDLE;
                end else if (ordering && lvl_first) begin
                    d.state = ST_ARMED;
                end else if (!ordering && trigger) begin
                    load = 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.viol  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign violation = q.viol;
    assign busy      = (q.state != ST_IDLE);

    // R10
    viol_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> !busy);

    // R8
    end_mode_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (violation && $past(mode) == MODE_END) |-> ($past(q.state) == ST_COUNT));

    // R2
    arm_to_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_ARMED && ordering && first_fall && !second_rise)
        |=> (q.state == ST_COUNT));

    // R7
    early_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != ST_COUNT && ordering && second_rise) |=> violation);
endmodule

// File: tb/tb_tick_window_monitor.sv
module tb_tick_window_monitor;
    localparam int BW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b0;
    logic a = 1'b0, b = 1'b0, e = 1'b0, t = 1'b0;
    logic [BW-1:0] lo = '0, hi = '0;
    logic violation, busy;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    // reference model state
    int ms, mcnt, mlo, mhi;
    logic pa, pb, ev, eb;

    always #5 clk = ~clk;

    tick_window_monitor #(.BOUND_W(BW)) dut (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .lvl_first(a), .lvl_second(b), .trigger(e), .tick(t),
        .bound_lo(lo), .bound_hi(hi),
        .violation(violation), .busy(busy)
    );

    task automatic check(string tag, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic fits_f(int c, int l, int h);
        return ((l == 0) || (c >= l)) && ((h == 0) || (c <= h));
    endfunction

    // advance the model by one cycle with the current inputs
    task automatic model_step();
        logic af, br, tgt, ordr, exp_i;
        int nx;
        af = pa & ~a;
        br = ~pb & b;
        ordr = (mode == 1'b0);
        tgt = ordr ? br : af;
        nx = (mcnt >= 511) ? mcnt : mcnt + int'(t);
        exp_i = (mhi != 0) && t && (mcnt >= mhi);
        ev = 1'b0;
        case (ms)
            0: if (ordr) begin
                   if (br) ev = 1'b1;
                   else if (a) ms = 1;
               end else if (e) begin
                   mcnt = 0; mlo = lo; mhi = hi; ms = 2;
               end
            1: if (!ordr) ms = 0;
               else if (br) begin ev = 1'b1; ms = 0; end
               else if (af) begin mcnt = 0; mlo = lo; mhi = hi; ms = 2; end
            default: begin
                if (tgt) begin ev = !fits_f(nx, mlo, mhi); ms = 0; mcnt = nx; end
                else if (exp_i) begin ev = 1'b1; ms = 0; mcnt = nx; end
                else if (ordr && a) begin ms = 1; mcnt = nx; end
                else if (!ordr && e) begin mcnt = 0; mlo = lo; mhi = hi; end
                else mcnt = nx;
            end
        endcase
        eb = (ms != 0);
        pa = a;
        pb = b;
    endtask

    // drive at negedge (already there), clock once, sample at next negedge
    task automatic cyc(logic na, logic nb, logic ne, logic nt, string tag);
        a = na; b = nb; e = ne; t = nt;
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(tag, violation, ev, "violation vs model");
        check(tag, busy, eb, "busy vs model");
    endtask

    task automatic expect_now(string tag, logic v, logic bz);
        check(tag, violation, v, "violation (directed)");
        check(tag, busy, bz, "busy (directed)");
    endtask

    task automatic do_reset(logic m, int l, int h);
        rst_n = 1'b0; a = 0; b = 0; e = 0; t = 0;
        mode = m; lo = BW'(l); hi = BW'(h);
        ms = 0; mcnt = 0; mlo = 0; mhi = 0; pa = 0; pb = 0;
        @(negedge clk); @(negedge clk);
        check("R1", violation, 1'b0, "violation in reset");
        check("R1", busy, 1'b0, "busy in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", violation, 1'b0, "violation after reset");
        check("R1", busy, 1'b0, "busy after reset");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5eed_0042));
        @(negedge clk);

        // R2 R3: ordering [2,4], tick in exit cycle not counted, tick with B counted
        do_reset(1'b0, 2, 4);
        cyc(1, 0, 0, 0, "R2"); expect_now("R2", 0, 1);
        cyc(0, 0, 0, 1, "R2"); expect_now("R2", 0, 1);
        cyc(0, 0, 0, 1, "R3");
        cyc(0, 1, 0, 1, "R3"); expect_now("R3", 0, 0);
        cyc(0, 0, 0, 0, "R3");

        // R4 early, R10 single pulse
        do_reset(1'b0, 2, 4);
        cyc(1, 0, 0, 0, "R4");
        cyc(0, 0, 0, 0, "R4");
        cyc(0, 0, 0, 1, "R4");
        cyc(0, 1, 0, 0, "R4"); expect_now("R4", 1, 0);
        cyc(0, 1, 0, 0, "R10"); expect_now("R10", 0, 0);

        // R5 timeout at [1,2]
        do_reset(1'b0, 1, 2);
        cyc(1, 0, 0, 0, "R5");
        cyc(0, 0, 0, 0, "R5");
        cyc(0, 0, 0, 1, "R5");
        cyc(0, 0, 0, 1, "R5"); expect_now("R5", 0, 1);
        cyc(0, 0, 0, 1, "R5"); expect_now("R5", 1, 0);

        // R3 exact [3,3] with B on the third tick
        do_reset(1'b0, 3, 3);
        cyc(1, 0, 0, 0, "R3");
        cyc(0, 0, 0, 0, "R3");
        cyc(0, 0, 0, 1, "R3");
        cyc(0, 0, 0, 1, "R3");
        cyc(0, 1, 0, 1, "R3"); expect_now("R3", 0, 0);

        // R6 [0,0] pure ordering, R7 B while idle
        do_reset(1'b0, 0, 0);
        cyc(1, 0, 0, 0, "R6");
        cyc(0, 0, 0, 0, "R6");
        for (int i = 0; i < 300; i++) cyc(0, 0, 0, 1, "R6");
        expect_now("R6", 0, 1);
        cyc(0, 1, 0, 0, "R6"); expect_now("R6", 0, 0);
        cyc(0, 0, 0, 0, "R7");
        cyc(0, 1, 0, 0, "R7"); expect_now("R7", 1, 0);
        cyc(0, 0, 0, 0, "R7");
        cyc(1, 0, 0, 0, "R7");
        cyc(1, 1, 0, 0, "R7"); expect_now("R7", 1, 0);
        cyc(0, 0, 0, 0, "R7");

        // R8 ending [3,7]
        do_reset(1'b1, 3, 7);
        cyc(1, 0, 0, 0, "R8"); expect_now("R8", 0, 0);
        cyc(1, 0, 1, 1, "R8"); expect_now("R8", 0, 1);
        cyc(1, 1, 0, 1, "R8");
        cyc(1, 0, 0, 1, "R8");
        cyc(0, 0, 0, 1, "R8"); expect_now("R8", 0, 0);
        cyc(1, 0, 0, 0, "R8");
        cyc(0, 0, 0, 0, "R8"); expect_now("R8", 0, 0);
        cyc(1, 0, 1, 0, "R8");
        cyc(1, 0, 0, 1, "R8");
        cyc(0, 0, 0, 0, "R8"); expect_now("R8", 1, 0);

        // R9 restart in ordering mode [2,2]
        do_reset(1'b0, 2, 2);
        cyc(1, 0, 0, 0, "R9");
        cyc(0, 0, 0, 0, "R9");
        cyc(0, 0, 0, 1, "R9");
        cyc(1, 0, 0, 0, "R9");
        cyc(0, 0, 0, 0, "R9");
        cyc(0, 0, 0, 1, "R9");
        cyc(0, 0, 0, 1, "R9");
        cyc(0, 1, 0, 0, "R9"); expect_now("R9", 0, 0);

        // R9 restart in ending mode [3,5]
        do_reset(1'b1, 3, 5);
        cyc(1, 0, 1, 0, "R9");
        cyc(1, 0, 0, 1, "R9");
        cyc(1, 0, 0, 1, "R9");
        cyc(1, 0, 1, 0, "R9");
        cyc(1, 0, 0, 1, "R9");
        cyc(1, 0, 0, 1, "R9");
        cyc(0, 0, 0, 0, "R9"); expect_now("R9", 1, 0);

        // R11 bounds sampled at count start
        do_reset(1'b0, 1, 2);
        cyc(1, 0, 0, 0, "R11");
        cyc(0, 0, 0, 0, "R11");
        lo = BW'(5); hi = BW'(9);
        cyc(0, 0, 0, 1, "R11");
        cyc(0, 1, 0, 0, "R11"); expect_now("R11", 0, 0);

        // constrained random segments against the model
        for (int s = 0; s < 24; s++) begin
            int l, h;
            l = int'($urandom_range(0, 4));
            h = ($urandom_range(0, 3) == 0) ? 0 : l + int'($urandom_range(0, 4));
            do_reset(logic'(s % 2), l, h);
            for (int c = 0; c < 400; c++) begin
                logic na, nb;
                na = ($urandom_range(0, 7) == 0) ? ~a : a;
                nb = ($urandom_range(0, 9) == 0) ? ~b : b;
                if ($urandom_range(0, 49) == 0) begin
                    lo = BW'($urandom_range(0, 4));
                    hi = BW'($urandom_range(0, 8));
                end
                cyc(na, nb, ($urandom_range(0, 11) == 0), ($urandom_range(0, 2) == 0),
                    (s % 2 == 0) ? "R2" : "R8");
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule